// File: doc/BRIEF.md
# Pulse Density Clock Trim Modulator

This block steers an external voltage-controlled crystal oscillator by producing a pulse-density stream that an analog loop filter averages into a tuning voltage. A 16-bit control word, loaded through a simple write port, sets how many pulses appear in each run of 65,536 clocks. The count is the all-ones value minus the control word, so a fully set word gives a quiet line. The line rests high and each pulse is a single clock low.

Pulses are spread with a first-order accumulator. On every clock the step (all-ones minus the control word) is added to a 16-bit running sum, and every carry out of that sum becomes one low cycle on the output. This places the pulses as evenly as integer arithmetic allows. A control word near 0x9140 is the nominal trim for a 27 MHz center. Software writes a new word at any time. The word is used from the next clock, and the running sum carries on from where it was.

Top module: `pdm_trim_top`

## Requirements
- R1: While reset is low at a clock edge, the output becomes high, the control word becomes 0xFFFF and the running sum becomes zero; with no write after reset the output stays high.
- R2: With control word 0xFFFF the output stays high in every cycle and the running sum does not change.
- R3: Starting from a cleared sum, the number of low cycles in the first 65,536 cycles after a word takes effect equals 0xFFFF minus the word: 1 for 0xFFFE, 3 for 0xFFFC, and in general floor(N*step/65536) in the first N cycles (2000 cycles of 0xFFFF give 0, 32,768 cycles of 0xFFFD give 1, 4096 cycles of 0x9140 give 1771).
- R4: Each pulse is one clock low and the output is high in all other cycles; when the step is at most 0x8000, two lows never fall in consecutive cycles.
- R5: The spacing between consecutive pulses is within one clock of 65536/step (0x9140 gives spacings of 2 or 3 cycles, 0x7FFF exactly 2, 0xFFFC 21,845 or 21,846).
- R6: From a cleared sum, the first pulse appears in cycle ceil(65536/step) counted from the first cycle that uses the word (cycle 1 is the output after the first addition).
- R7: A word captured at a clock edge is used for the addition at the following edge; 0x7FFF written after reset gives its first low output in the second cycle after the capture edge.
- R8: A write does not clear the running sum: after 0x7FFF is used for one addition and then 0xFFFF holds the sum at 0x8000, writing 0xBFFF gives a low output in the second cycle after its capture edge.
- R9: The word on wr_data is captured only at an edge where wr_en is high; with wr_en low, changes on wr_data have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Capture wr_data into the control word at this edge |
| wr_data | input | 16 | New control word |
| trim_out | output | 1 | Pulse-density output, idles high, one-clock low pulses |

## Verification
The assertions take for granted that wr_en and wr_data are settled before each rising edge and that reset is held low through at least one edge before the first check cycle; the bench drives both on the falling edge and starts with reset low from time zero. The spacing assertion assumes nothing about the written values beyond their width, and the bench keeps each control word fixed over a whole measured run so counts and first-pulse positions follow the closed-form expectations. Writes that land mid-run are confined to the directed tests that check sum continuity and write-enable gating.

// File: rtl/pdm_trim_pkg.sv
// Package: shared constants for the pulse density clock trim modulator.
// Assumes: a single control word width is used across all submodules.
package pdm_trim_pkg;
    parameter int unsigned CTRL_W = 16;
endpackage

// File: rtl/pdm_trim_ctrl_reg.sv
// Module: control word register.
// Holds the programmed word; loads wr_data on edges with wr_en high.
// Assumes: synchronous active-low reset; reset value is all ones (no pulses).
module pdm_trim_ctrl_reg #(
    parameter int unsigned W = pdm_trim_pkg::CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] step
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    // Register the control word, forced to all ones in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= ALL_ONES;
        else if (wr_en)
            ctrl_q <= wr_data;
    end

    // Step is the all-ones value minus the control word.
    always_comb begin
        step = ALL_ONES - ctrl_q;
    end

    // R9 R7
    // write_capture_chk
    write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q == $past(wr_data)));

    // R9
    // write_hold_chk
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(ctrl_q));
endmodule

// File: rtl/pdm_trim_accum.sv
// Module: first-order accumulator.
// Adds the step to a running sum every clock; the carry out marks a pulse.
// Assumes: step is stable within a cycle; sum wraps modulo 2^W.
module pdm_trim_accum #(
    parameter int unsigned W = pdm_trim_pkg::CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] step,
    output logic         carry
);
    logic [W-1:0] acc_q;
    logic [W:0]   total;

    // Form the wide sum whose top bit is the carry.
    always_comb begin
        total = {1'b0, acc_q} + {1'b0, step};
        carry = total[W];
    end

    // Advance the running sum, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= total[W-1:0];
    end

    // R1
    // acc_reset_chk
    acc_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0));

    // R2
    // acc_hold_chk
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0) |=> $stable(acc_q));
endmodule

// File: rtl/pdm_trim_out_stage.sv
// Module: output register.
// Turns each carry into one registered low cycle; idles high.
// Assumes: carry is a single-cycle combinational pulse request.
module pdm_trim_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic carry,
    output logic trim_out
);
    // Register the active-low pulse, high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trim_out <= 1'b1;
        else
            trim_out <= ~carry;
    end
endmodule

// File: rtl/pdm_trim_top.sv
// Module: pulse density clock trim modulator top.
// Chains control register, accumulator and output register.
// Assumes: wr_en/wr_data meet setup to clk; reset is synchronous active low.
module pdm_trim_top #(
    parameter int unsigned W = pdm_trim_pkg::CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         trim_out
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] HALF     = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] ctrl_q;
    logic [W-1:0] step;
    logic         carry;

    pdm_trim_ctrl_reg #(.W(W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .step    (step)
    );

    pdm_trim_accum #(.W(W)) accum_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .carry (carry)
    );

    pdm_trim_out_stage out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .carry    (carry),
        .trim_out (trim_out)
    );

    // R1
    // reset_state_chk
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (trim_out && ctrl_q == ALL_ONES));

    // R2
    // idle_high_chk
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == ALL_ONES) |=> trim_out);

    // R4
    // no_back_to_back_chk
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trim_out && $past(step) <= HALF && step <= HALF) |=> trim_out);
endmodule

// File: tb/pdm_trim_top_tb_top.sv
module pdm_trim_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic        trim_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pdm_trim_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .trim_out(trim_out)
    );

    // value, cycles, expected count, expected first pulse (0 none), min gap, max gap (0 skip)
    localparam int NV = 7;
    localparam int TBL [NV][6] = '{
        '{32'hFFFF,  2000,    0,     0,     0,     0},
        '{32'hFFFE, 65536,    1, 65536,     0,     0},
        '{32'hFFFD, 32768,    1, 32768,     0,     0},
        '{32'hFFFC, 65536,    3, 21846, 21845, 21846},
        '{32'h9140,  4096, 1771,     3,     2,     3},
        '{32'h7FFF,  1000,  500,     2,     2,     2},
        '{32'h0000,  1000,  999,     2,     1,     1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        int cnt, first, last, gmin, gmax, lows;
        // R1: reset state
        repeat (2) @(negedge clk);
        check(trim_out == 1'b1, "R1 output in reset", int'(trim_out), 1);
        rst_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (!trim_out) lows++;
        end
        check(lows == 0, "R1 no pulses before first write", lows, 0);

        // Table walk: R2 R3 R5 R6 R7 R4
        for (int v = 0; v < NV; v++) begin
            do_reset();
            write_word(TBL[v][0][15:0]);
            cnt = 0; first = 0; last = 0; gmin = 1 << 30; gmax = 0;
            for (int i = 1; i <= TBL[v][1]; i++) begin
                @(negedge clk);
                if (!trim_out) begin
                    cnt++;
                    if (first == 0) first = i;
                    else begin
                        if (i - last < gmin) gmin = i - last;
                        if (i - last > gmax) gmax = i - last;
                    end
                    last = i;
                end
            end
            check(cnt == TBL[v][2], (TBL[v][0] == 32'hFFFF) ? "R2 idle count" : "R3 pulse count",
                  cnt, TBL[v][2]);
            if (TBL[v][3] != 0)
                check(first == TBL[v][3], (TBL[v][0] == 32'h7FFF) ? "R7 first pulse" : "R6 first pulse",
                      first, TBL[v][3]);
            if (TBL[v][4] != 0) begin
                check(gmin >= TBL[v][4], "R4 R5 min spacing", gmin, TBL[v][4]);
                check(gmax <= TBL[v][5], "R5 max spacing", gmax, TBL[v][5]);
            end
        end

        // R1: reset during an active run returns output high and word to idle
        do_reset();
        write_word(16'h0000);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(trim_out == 1'b1, "R1 output after mid-run reset", int'(trim_out), 1);
        rst_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!trim_out) lows++;
        end
        check(lows == 0, "R1 word restored to idle", lows, 0);

        // R8: write keeps the running sum
        do_reset();
        wr_en = 1'b1; wr_data = 16'h7FFF;
        @(negedge clk);
        wr_data = 16'hFFFF;
        @(negedge clk);
        wr_en = 1'b0;
        check(trim_out == 1'b1, "R8 after first addition", int'(trim_out), 1);
        lows = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!trim_out) lows++;
        end
        check(lows == 0, "R8 hold with idle word", lows, 0);
        wr_en = 1'b1; wr_data = 16'hBFFF;
        @(negedge clk);
        wr_en = 1'b0;
        check(trim_out == 1'b1, "R8 capture cycle", int'(trim_out), 1);
        @(negedge clk);
        check(trim_out == 1'b1, "R8 one addition", int'(trim_out), 1);
        @(negedge clk);
        check(trim_out == 1'b0, "R8 carry from kept sum", int'(trim_out), 0);

        // R9: data changes with wr_en low have no effect
        do_reset();
        wr_en = 1'b0;
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            wr_data = 16'(i * 37);
            @(negedge clk);
            if (!trim_out) lows++;
        end
        check(lows == 0, "R9 ungated data ignored", lows, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule